// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block is a small shared word store with several requester ports. It performs indivisible read-modify-write operations on lock and counter variables. Each requester presents an operation code, a word address and a write value under a valid/ready handshake. The unit supports five operations: plain load, plain store, atomic exchange, test-and-set and fetch-and-increment. Every operation returns the word's contents as they were before the update.

A round-robin arbiter picks at most one requester per clock. The chosen operation reads the addressed word, computes the new value and writes it back within that single cycle. This means no other access can fall between the read and the write of one operation. Loads and stores use the same arbitrated path, so their order relative to the atomic operations is kept. A lock word holds 0 when free and 1 when taken. A requester acquires the lock with an exchange or test-and-set, and it owns the lock when the returned value is 0.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset every word reads 0, no response is pending, and no port is made ready while it has no request.
- R2: At most one port is made ready in any cycle, and only a port whose request is valid.
- R3: The arbiter is round robin. After a grant to port p, the search for the next grant starts at port p+1 (wrapping to 0), so ports that request continuously are served in rotating order.
- R4: An operation is accepted on the clock edge where its valid and ready are both high. In the next cycle only, that port's response valid is high and the shared response data carries the word's value from before the update.
- R5: Opcode 0 (load) returns the word and leaves it unchanged.
- R6: Opcode 1 (store) writes the request value and returns the previous contents.
- R7: Opcode 2 (exchange) writes the request value and returns the previous contents.
- R8: Opcode 3 (test-and-set) writes 1 only when the stored word is 0, and otherwise leaves it unchanged. It ignores the request value and returns the previous contents in both cases.
- R9: Opcode 4 (fetch-and-increment) returns the previous contents and stores that value plus one, modulo 2^DATA_W.
- R10: When ports compete for the same word, the operations take effect one after another in grant order. Of several simultaneous test-and-sets on a free lock, exactly one sees 0. Simultaneous increments each see a distinct value.
- R11: Opcodes 5 to 7 behave as loads and never modify memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_PORTS | Request valid, one bit per port |
| req_ready | output | NUM_PORTS | Request accepted this cycle, one bit per port |
| req_op | input | NUM_PORTS*3 | Opcode per port, port i in bits [3i+2:3i] |
| req_addr | input | NUM_PORTS*ADDR_W | Word address per port |
| req_wdata | input | NUM_PORTS*DATA_W | Write value per port |
| rsp_valid | output | NUM_PORTS | One-cycle response pulse per port |
| rsp_data | output | DATA_W | Pre-update word of the operation being answered |

## Verification
The hardest case to reach from the ports is contention. Two or more ports must fight for the same word in the same cycle, and their operations must then land on consecutive cycles, so that one operation's read sees the previous operation's write. The bench raises all three requests on one edge, with test-and-set on a free lock and then with increments of a counter. It holds each request until that request is granted. It then checks that exactly one port won the lock and that the counter values returned were distinct and consecutive. The arbiter pointer is first set to a known position by a single operation on the last port, so the rotation order can be predicted exactly.

// File: rtl/amu_pkg.sv
package amu_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_SWAP  = 3'd2,
        OP_TAS   = 3'd3,
        OP_FINC  = 3'd4
    } amu_op_e;

    // Decode an opcode field; unknown codes fall back to a load.
    function automatic amu_op_e decode_op(input logic [OP_W-1:0] raw);
        case (raw)
            3'd1:    return OP_STORE;
            3'd2:    return OP_SWAP;
            3'd3:    return OP_TAS;
            3'd4:    return OP_FINC;
            default: return OP_LOAD;
        endcase
    endfunction

endpackage

// File: rtl/amu_rr_arbiter.sv
module amu_rr_arbiter #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] gnt_idx;
    logic             found;

    always_comb begin
        int idx;
        grant   = '0;
        gnt_idx = '0;
        found   = 1'b0;
        idx     = 0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(ptr_q) + k) % N;
            if (!found && req[idx]) begin
                grant[idx] = 1'b1;
                gnt_idx    = IDX_W'(idx);
                found      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (found) begin
            ptr_q <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
        end
    end

    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

endmodule

// File: rtl/amu_rmw_alu.sv
module amu_rmw_alu
    import amu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [OP_W-1:0]   op_raw,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] req_val,
    output logic              wr_en,
    output logic [DATA_W-1:0] new_val
);
    amu_op_e op;

    always_comb begin
        op      = decode_op(op_raw);
        wr_en   = 1'b0;
        new_val = old_val;
        case (op)
            OP_STORE, OP_SWAP: begin
                wr_en   = 1'b1;
                new_val = req_val;
            end
            OP_TAS: begin
                wr_en   = (old_val == '0);
                new_val = DATA_W'(1);
            end
            OP_FINC: begin
                wr_en   = 1'b1;
                new_val = old_val + 1'b1;
            end
            default: begin
                wr_en   = 1'b0;
                new_val = old_val;
            end
        endcase
    end

endmodule

// File: rtl/amu_word_store.sv
module amu_word_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rdata,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    assign rdata = mem_q[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
    import amu_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PORTS-1:0]          req_valid,
    output logic [NUM_PORTS-1:0]          req_ready,
    input  logic [NUM_PORTS*OP_W-1:0]     req_op,
    input  logic [NUM_PORTS*ADDR_W-1:0]   req_addr,
    input  logic [NUM_PORTS*DATA_W-1:0]   req_wdata,
    output logic [NUM_PORTS-1:0]          rsp_valid,
    output logic [DATA_W-1:0]             rsp_data
);
    logic [OP_W-1:0]   op_a   [NUM_PORTS];
    logic [ADDR_W-1:0] addr_a [NUM_PORTS];
    logic [DATA_W-1:0] data_a [NUM_PORTS];

    generate
        for (genvar g = 0; g < NUM_PORTS; g++) begin : g_unpack
            assign op_a[g]   = req_op[g*OP_W +: OP_W];
            assign addr_a[g] = req_addr[g*ADDR_W +: ADDR_W];
            assign data_a[g] = req_wdata[g*DATA_W +: DATA_W];
        end
    endgenerate

    logic [NUM_PORTS-1:0] arb_req;
    logic [NUM_PORTS-1:0] grant;

    assign arb_req = req_valid & {NUM_PORTS{!rst}};

    amu_rr_arbiter #(.N(NUM_PORTS)) arb_i (
        .clk   (clk),
        .rst   (rst),
        .req   (arb_req),
        .grant (grant)
    );

    assign req_ready = grant;

    logic              acc;
    logic [OP_W-1:0]   sel_op;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_data;

    always_comb begin
        acc      = |grant;
        sel_op   = '0;
        sel_addr = '0;
        sel_data = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (grant[i]) begin
                sel_op   = op_a[i];
                sel_addr = addr_a[i];
                sel_data = data_a[i];
            end
        end
    end

    logic [DATA_W-1:0] old_val;
    logic [DATA_W-1:0] new_val;
    logic              alu_we;

    amu_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
        .clk   (clk),
        .rst   (rst),
        .addr  (sel_addr),
        .rdata (old_val),
        .we    (acc && alu_we),
        .wdata (new_val)
    );

    amu_rmw_alu #(.DATA_W(DATA_W)) alu_i (
        .op_raw  (sel_op),
        .old_val (old_val),
        .req_val (sel_data),
        .wr_en   (alu_we),
        .new_val (new_val)
    );

    logic [NUM_PORTS-1:0] rsp_valid_q;
    logic [DATA_W-1:0]    rsp_data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= '0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= grant;
            if (acc) begin
                rsp_data_q <= old_val;
            end
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;

    p_rsp_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_valid));

    generate
        for (genvar g = 0; g < NUM_PORTS; g++) begin : g_chk
            p_rsp_follows_accept_r4: assert property (@(posedge clk) disable iff (rst)
                rsp_valid[g] |-> $past(req_valid[g] && req_ready[g]));
        end
    endgenerate

    // Back-to-back accesses to one word observe the prior increment.
    p_finc_chain_r9: assert property (@(posedge clk) disable iff (rst)
        (acc && $past(acc && sel_op == 3'd4) && sel_addr == $past(sel_addr))
        |-> old_val == DATA_W'($past(old_val) + 1'b1));

    // A failing test-and-set leaves the word untouched for the next access.
    p_tas_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (acc && $past(acc && sel_op == 3'd3 && old_val != '0) && sel_addr == $past(sel_addr))
        |-> old_val == $past(old_val));

endmodule

// File: tb/atomic_mem_unit_tb.sv
module atomic_mem_unit_tb_top;
    localparam int NP = 3;
    localparam int AW = 4;
    localparam int DW = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic [NP-1:0]     req_valid;
    logic [NP-1:0]     req_ready;
    logic [NP*3-1:0]   req_op;
    logic [NP*AW-1:0]  req_addr;
    logic [NP*DW-1:0]  req_wdata;
    logic [NP-1:0]     rsp_valid;
    logic [DW-1:0]     rsp_data;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    atomic_mem_unit #(.NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_port(input int p, input logic [2:0] op, input logic [AW-1:0] a,
                            input logic [DW-1:0] wd);
        req_op[p*3 +: 3]     = op;
        req_addr[p*AW +: AW] = a;
        req_wdata[p*DW +: DW] = wd;
        req_valid[p]         = 1'b1;
    endtask

    // Single operation on one port; returns pre-update data.
    task automatic do_op(input int p, input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, output logic [DW-1:0] old);
        @(negedge clk);
        set_port(p, op, a, wd);
        #1;
        while (!req_ready[p]) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid[p] = 1'b0;
        check(rsp_valid == NP'(1 << p), "R4 response pulse", int'(rsp_valid), 1 << p);
        old = rsp_data;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        @(negedge clk);
        check(rsp_valid == '0, "R1 no response after reset", int'(rsp_valid), 0);
        check(req_ready == '0, "R1 no ready while idle", int'(req_ready), 0);
        do_op(1, 3'd0, 4'd3, 8'h00, v);
        check(v == 8'h00, "R1 word zero after reset", int'(v), 0);
        @(negedge clk);
        check(rsp_valid == '0, "R4 pulse lasts one cycle", int'(rsp_valid), 0);
    endtask

    task automatic t_load_store();
        logic [DW-1:0] v;
        do_op(0, 3'd1, 4'd2, 8'hA5, v);
        check(v == 8'h00, "R6 store returns old", int'(v), 0);
        do_op(1, 3'd0, 4'd2, 8'h11, v);
        check(v == 8'hA5, "R5 load returns word", int'(v), 'hA5);
        do_op(2, 3'd0, 4'd2, 8'h22, v);
        check(v == 8'hA5, "R5 load leaves word", int'(v), 'hA5);
    endtask

    task automatic t_swap();
        logic [DW-1:0] v;
        do_op(2, 3'd2, 4'd2, 8'h3C, v);
        check(v == 8'hA5, "R7 exchange returns old", int'(v), 'hA5);
        do_op(0, 3'd0, 4'd2, 8'h00, v);
        check(v == 8'h3C, "R7 exchange wrote value", int'(v), 'h3C);
    endtask

    task automatic t_tas();
        logic [DW-1:0] v;
        do_op(0, 3'd3, 4'd4, 8'h77, v);
        check(v == 8'h00, "R8 tas on free lock returns 0", int'(v), 0);
        do_op(1, 3'd0, 4'd4, 8'h00, v);
        check(v == 8'h01, "R8 tas sets 1", int'(v), 1);
        do_op(1, 3'd3, 4'd4, 8'h77, v);
        check(v == 8'h01, "R8 tas on held lock returns 1", int'(v), 1);
        do_op(2, 3'd1, 4'd4, 8'h80, v);
        do_op(2, 3'd3, 4'd4, 8'h00, v);
        check(v == 8'h80, "R8 tas returns nonzero old", int'(v), 'h80);
        do_op(0, 3'd0, 4'd4, 8'h00, v);
        check(v == 8'h80, "R8 failed tas leaves word", int'(v), 'h80);
    endtask

    task automatic t_finc();
        logic [DW-1:0] v;
        do_op(0, 3'd1, 4'd7, 8'hFF, v);
        do_op(1, 3'd4, 4'd7, 8'h00, v);
        check(v == 8'hFF, "R9 finc returns old", int'(v), 'hFF);
        do_op(2, 3'd0, 4'd7, 8'h00, v);
        check(v == 8'h00, "R9 finc wraps", int'(v), 0);
        do_op(2, 3'd4, 4'd7, 8'h00, v);
        do_op(0, 3'd0, 4'd7, 8'h00, v);
        check(v == 8'h01, "R9 finc adds one", int'(v), 1);
    endtask

    task automatic t_badop();
        logic [DW-1:0] v;
        do_op(1, 3'd6, 4'd7, 8'h55, v);
        check(v == 8'h01, "R11 unknown op returns word", int'(v), 1);
        do_op(1, 3'd0, 4'd7, 8'h00, v);
        check(v == 8'h01, "R11 unknown op does not write", int'(v), 1);
    endtask

    task automatic t_round_robin();
        logic [DW-1:0] v;
        do_op(2, 3'd0, 4'd0, 8'h00, v);   // pointer now at port 0
        @(negedge clk);
        for (int p = 0; p < NP; p++) set_port(p, 3'd0, AW'(p), 8'h00);
        for (int k = 0; k < 4; k++) begin
            #1;
            check(req_ready == NP'(1 << (k % NP)), "R3 rotating grant", int'(req_ready), 1 << (k % NP));
            check($countones(req_ready) <= 1, "R2 single grant", $countones(req_ready), 1);
            @(negedge clk);
        end
        req_valid = '0;
        @(negedge clk);
    endtask

    task automatic run_contention(input logic [2:0] op, output logic [DW-1:0] res [NP]);
        @(negedge clk);
        for (int p = 0; p < NP; p++) set_port(p, op, 4'd9, 8'h00);
        for (int n = 0; n < NP; n++) begin
            int g;
            g = -1;
            #1;
            for (int p = 0; p < NP; p++) if (req_ready[p]) g = p;
            check(g >= 0, "R2 a waiting port is granted", g, 0);
            @(posedge clk);
            @(negedge clk);
            if (g >= 0) begin
                res[g] = rsp_data;
                req_valid[g] = 1'b0;
            end
        end
    endtask

    task automatic t_contend();
        logic [DW-1:0] v;
        logic [DW-1:0] res [NP];
        int zeros;
        int sum;
        do_op(0, 3'd1, 4'd9, 8'h00, v);
        run_contention(3'd3, res);
        zeros = 0;
        for (int p = 0; p < NP; p++) if (res[p] == 8'h00) zeros++;
        check(zeros == 1, "R10 one lock winner", zeros, 1);
        do_op(0, 3'd1, 4'd9, 8'd10, v);
        run_contention(3'd4, res);
        sum = 0;
        for (int p = 0; p < NP; p++) sum += int'(res[p]);
        check(sum == 33 && res[0] != res[1] && res[1] != res[2] && res[0] != res[2],
              "R10 distinct increments", sum, 33);
        do_op(1, 3'd0, 4'd9, 8'h00, v);
        check(v == 8'd13, "R10 final counter", int'(v), 13);
    endtask

    initial begin
        req_valid = '0;
        req_op    = '0;
        req_addr  = '0;
        req_wdata = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_store();
        t_swap();
        t_tas();
        t_finc();
        t_badop();
        t_round_robin();
        t_contend();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule